// File: doc/BRIEF.md
# Phase-Frequency Comparator with Charge-Pump Steering

This block sits between the two programmable dividers of a frequency synthesizer and the analog charge pump. It compares the divided reference pulse train with the divided local-oscillator pulse train in a two-flag phase-frequency detector. From that comparison it decides, every clock cycle, whether the pump sources current, sinks current or floats. The pump stage and the loop filter are outside the block; the block only produces their control levels.

The block also watches the width of each error pulse to decide whether the loop is locked. Software can ask for the high pump current to speed up acquisition. Once lock is reached, the block drops to the low current by itself and reports this through an active-low flag. The block restores the programmed current as soon as lock is lost.

A three-bit test code can override the pump: it can float it, force it to sink or force it to source. Two test codes copy one of the divider pulse trains to a test pin, so that the divider frequencies can be measured from outside.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: In phase-controlled operation, a local pulse that arrives d cycles before the reference pulse drives `pump_src` high for exactly d cycles. It goes high two clock edges after the local pulse is sampled. `pump_snk` stays low.
- R2: In phase-controlled operation, a local pulse that arrives d cycles after the reference pulse drives `pump_snk` high for exactly d cycles. `pump_src` stays low.
- R3: `pump_hiz` is high exactly when neither `pump_src` nor `pump_snk` is high, and the two are never high together. Pulses that arrive in the same cycle leave the pump floating for the whole period.
- R4: While the loop is unlocked, `cur_hi` follows `cur_sel`: 0 selects the low current and 1 selects the high current.
- R5: `lock_flag` rises after 4 consecutive completed comparisons whose error width is below LOCK_TOL cycles (default 3). After only 3 such comparisons it is still low.
- R6: `lock_flag` falls as soon as an error pulse reaches LOCK_TOL cycles. `cur_hi` then returns to the programmed value and `auto_flag` returns to 1.
- R7: While locked with `cur_sel`=1, `cur_hi` is 0 and `auto_flag` is 0. In every other case `auto_flag` is 1.
- R8: `tmode` encoding. 000 with `cur_sel`=0 turns the pump off (floating). 000 with `cur_sel`=1 gives phase control. 001 floats the pump. 010 forces sink. 011 forces source. 100 floats the pump. 101 gives phase control. 110 and 111 float the pump.
- R9: `test_out` repeats `ref_pulse` one cycle later when `tmode` is 100. It repeats `loc_pulse` one cycle later when `tmode` is 101. It is 0 for every other code.
- R10: After reset, the pump floats, `lock_flag` is 0, `cur_hi` is 0, `auto_flag` is 1 and `test_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | One-cycle pulse from the reference divider |
| loc_pulse | input | 1 | One-cycle pulse from the local divider |
| cur_sel | input | 1 | Programmed pump current, 1 = high |
| tmode | input | 3 | Test-mode code |
| pump_src | output | 1 | Pump sources current |
| pump_snk | output | 1 | Pump sinks current |
| pump_hiz | output | 1 | Pump output floats |
| cur_hi | output | 1 | Effective current select, 1 = high |
| lock_flag | output | 1 | Loop locked |
| auto_flag | output | 1 | 0 while automatic low current is in effect |
| test_out | output | 1 | Divider pulse routed to the test pin |

## Verification
The assertions assume that `ref_pulse` and `loc_pulse` are single-cycle strobes. They also assume that `tmode` and `cur_sel` are quasi-static, so that a check against the previous cycle's code is meaningful. The bench keeps to this: it changes the code and the current select only inside a reset or a warm-up period, and it places each divider pulse alone at a fixed slot of a 16-cycle period. It sweeps the lead/lag offset from -6 to +6 cycles, which stays inside the period and crosses the lock tolerance on both sides.

// File: rtl/pfd_cp_pkg.sv
package pfd_cp_pkg;

  typedef enum logic [2:0] {
    TM_NORMAL  = 3'b000,
    TM_FLOAT   = 3'b001,
    TM_SINK    = 3'b010,
    TM_SOURCE  = 3'b011,
    TM_REF_PIN = 3'b100,
    TM_LOC_PIN = 3'b101,
    TM_FLOAT6  = 3'b110,
    TM_FLOAT7  = 3'b111
  } tmode_e;

  // phase control allowed for this code and current setting
  function automatic logic phase_ctl(input tmode_e m, input logic cs);
    return ((m == TM_NORMAL) && cs) || (m == TM_LOC_PIN);
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int LOCK_TOL = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_p,
  input  logic loc_p,
  output logic src_q,
  output logic snk_q,
  output logic cmp_ok,
  output logic cmp_bad
);
  localparam int CW = $clog2(LOCK_TOL + 1);
  localparam int WW = $clog2(LOCK_TOL + 2);

  logic          src_set, snk_set, done, active;
  logic [CW-1:0] cnt;
  logic [WW-1:0] width_now;

  assign src_set = src_q | loc_p;
  assign snk_set = snk_q | ref_p;
  assign done    = src_set & snk_set;
  assign active  = src_q | snk_q;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      src_q <= 1'b0;
      snk_q <= 1'b0;
    end else begin
      src_q <= src_set;
      snk_q <= snk_set;
    end
  end

  // width of the running error pulse, saturating at the tolerance
  always_ff @(posedge clk) begin
    if (rst || done)
      cnt <= '0;
    else if (active && (cnt != CW'(LOCK_TOL)))
      cnt <= cnt + 1'b1;
  end

  assign width_now = WW'(cnt) + WW'(active);
  assign cmp_bad   = (width_now >= WW'(LOCK_TOL));
  assign cmp_ok    = done & ~cmp_bad;

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_ok,
  input  logic cmp_bad,
  output logic lock_q
);
  localparam int GW = $clog2(LOCK_CNT + 1);

  logic [GW-1:0] good;
  logic [GW-1:0] good_inc;

  assign good_inc = (good == GW'(LOCK_CNT)) ? good : good + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      good   <= '0;
      lock_q <= 1'b0;
    end else if (cmp_bad) begin
      good   <= '0;
      lock_q <= 1'b0;
    end else if (cmp_ok) begin
      good   <= good_inc;
      lock_q <= lock_q | (good_inc == GW'(LOCK_CNT));
    end
  end

endmodule

// File: rtl/pfd_out_ctrl.sv
module pfd_out_ctrl
  import pfd_cp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] tmode,
  input  logic       cur_sel,
  input  logic       src_q,
  input  logic       snk_q,
  input  logic       lock_q,
  input  logic       ref_p,
  input  logic       loc_p,
  output logic       pump_src,
  output logic       pump_snk,
  output logic       pump_hiz,
  output logic       cur_hi,
  output logic       auto_flag,
  output logic       test_out
);
  tmode_e m;
  logic   pc, src_n, snk_n, test_n, auto_act;

  assign m        = tmode_e'(tmode);
  assign pc       = phase_ctl(m, cur_sel);
  assign src_n    = pc ? src_q : (m == TM_SOURCE);
  assign snk_n    = pc ? snk_q : (m == TM_SINK);
  assign auto_act = lock_q & cur_sel;

  always_comb begin
    case (m)
      TM_REF_PIN: test_n = ref_p;
      TM_LOC_PIN: test_n = loc_p;
      default:    test_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_src  <= 1'b0;
      pump_snk  <= 1'b0;
      pump_hiz  <= 1'b1;
      cur_hi    <= 1'b0;
      auto_flag <= 1'b1;
      test_out  <= 1'b0;
    end else begin
      pump_src  <= src_n;
      pump_snk  <= snk_n;
      pump_hiz  <= ~(src_n | snk_n);
      cur_hi    <= cur_sel & ~auto_act;
      auto_flag <= ~auto_act;
      test_out  <= test_n;
    end
  end

endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl #(
  parameter int LOCK_TOL = 3,
  parameter int LOCK_CNT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_pulse,
  input  logic       loc_pulse,
  input  logic       cur_sel,
  input  logic [2:0] tmode,
  output logic       pump_src,
  output logic       pump_snk,
  output logic       pump_hiz,
  output logic       cur_hi,
  output logic       lock_flag,
  output logic       auto_flag,
  output logic       test_out
);
  logic src_q, snk_q, cmp_ok, cmp_bad, lock_q;

  pfd_core #(.LOCK_TOL(LOCK_TOL)) u_core (
    .clk(clk), .rst(rst), .ref_p(ref_pulse), .loc_p(loc_pulse),
    .src_q(src_q), .snk_q(snk_q), .cmp_ok(cmp_ok), .cmp_bad(cmp_bad)
  );

  pfd_lock_det #(.LOCK_CNT(LOCK_CNT)) u_lock (
    .clk(clk), .rst(rst), .cmp_ok(cmp_ok), .cmp_bad(cmp_bad), .lock_q(lock_q)
  );

  pfd_out_ctrl u_out (
    .clk(clk), .rst(rst), .tmode(tmode), .cur_sel(cur_sel),
    .src_q(src_q), .snk_q(snk_q), .lock_q(lock_q),
    .ref_p(ref_pulse), .loc_p(loc_pulse),
    .pump_src(pump_src), .pump_snk(pump_snk), .pump_hiz(pump_hiz),
    .cur_hi(cur_hi), .auto_flag(auto_flag), .test_out(test_out)
  );

  assign lock_flag = lock_q;

endmodule

// File: rtl/pfd_cp_ctrl_chk.sv
module pfd_cp_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ref_pulse,
  input logic       loc_pulse,
  input logic       cur_sel,
  input logic [2:0] tmode,
  input logic       pump_src,
  input logic       pump_snk,
  input logic       pump_hiz,
  input logic       cur_hi,
  input logic       lock_flag,
  input logic       auto_flag,
  input logic       test_out
);
  // R3: never source and sink at once
  a_r3_no_both: assert property (@(posedge clk) disable iff (rst)
    !(pump_src && pump_snk));

  // R3: float exactly when idle
  a_r3_hiz_idle: assert property (@(posedge clk) disable iff (rst)
    pump_hiz == !(pump_src || pump_snk));

  // R8: forced sink code
  a_r8_forced_sink: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tmode) == 3'b010) |-> (pump_snk && !pump_src));

  // R8: pump off with low current in normal code
  a_r8_pump_off: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tmode) == 3'b000 && !$past(cur_sel)) |-> pump_hiz);

  // R9: test pin only carries the selected divider pulse
  a_r9_test_route: assert property (@(posedge clk) disable iff (rst)
    test_out |-> (($past(tmode) == 3'b100 && $past(ref_pulse)) ||
                  ($past(tmode) == 3'b101 && $past(loc_pulse))));

  // R7: automatic low current only when locked with high current programmed
  a_r7_auto_cause: assert property (@(posedge clk) disable iff (rst)
    !auto_flag |-> ($past(lock_flag) && $past(cur_sel)));

  // R4: high current only when programmed
  a_r4_cur_prog: assert property (@(posedge clk) disable iff (rst)
    cur_hi |-> $past(cur_sel));

endmodule

bind pfd_cp_ctrl pfd_cp_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .loc_pulse(loc_pulse),
  .cur_sel(cur_sel), .tmode(tmode), .pump_src(pump_src), .pump_snk(pump_snk),
  .pump_hiz(pump_hiz), .cur_hi(cur_hi), .lock_flag(lock_flag),
  .auto_flag(auto_flag), .test_out(test_out)
);

// File: tb/pfd_cp_ctrl_tb.sv
module pfd_cp_ctrl_tb;
  localparam int TOL = 3;
  localparam int PER = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_pulse = 1'b0, loc_pulse = 1'b0, cur_sel = 1'b0;
  logic [2:0] tmode = 3'b000;
  logic pump_src, pump_snk, pump_hiz, cur_hi, lock_flag, auto_flag, test_out;

  int checks = 0, failures = 0;
  int n_src, n_snk, n_hiz, n_test, f_src, f_test;
  int e_lock, e_cur, e_auto;

  always #2 clk = ~clk;

  pfd_cp_ctrl u_dut (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .loc_pulse(loc_pulse),
    .cur_sel(cur_sel), .tmode(tmode), .pump_src(pump_src), .pump_snk(pump_snk),
    .pump_hiz(pump_hiz), .cur_hi(cur_hi), .lock_flag(lock_flag),
    .auto_flag(auto_flag), .test_out(test_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_pulse = 1'b0; loc_pulse = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // d > 0: local leads by d cycles; d < 0: local lags by -d cycles
  task automatic run_period(input int d);
    int tl, tr;
    tl = (d >= 0) ? 4 : 4 - d;
    tr = (d >= 0) ? 4 + d : 4;
    n_src = 0; n_snk = 0; n_hiz = 0; n_test = 0; f_src = -1; f_test = -1;
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      if (pump_src) begin n_src++; if (f_src < 0) f_src = c; end
      if (pump_snk) n_snk++;
      if (pump_hiz) n_hiz++;
      if (test_out) begin n_test++; if (f_test < 0) f_test = c; end
      e_lock = int'(lock_flag); e_cur = int'(cur_hi); e_auto = int'(auto_flag);
      loc_pulse = (c == tl);
      ref_pulse = (c == tr);
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int ad, lk;
    do_reset();
    // R10: reset state
    @(negedge clk);
    chk("R10 pump_src", int'(pump_src), 0);
    chk("R10 pump_snk", int'(pump_snk), 0);
    chk("R10 pump_hiz", int'(pump_hiz), 1);
    chk("R10 lock_flag", int'(lock_flag), 0);
    chk("R10 cur_hi", int'(cur_hi), 0);
    chk("R10 auto_flag", int'(auto_flag), 1);
    chk("R10 test_out", int'(test_out), 0);

    // sweep of lead/lag offsets in phase-controlled mode with high current
    for (int d = -6; d <= 6; d++) begin
      cur_sel = 1'b1; tmode = 3'b000;
      do_reset();
      for (int p = 0; p < 6; p++) run_period(d);
      ad = (d < 0) ? -d : d;
      lk = (ad < TOL) ? 1 : 0;
      chk($sformatf("R1 src width d=%0d", d), n_src, (d > 0) ? d : 0);
      chk($sformatf("R2 snk width d=%0d", d), n_snk, (d < 0) ? -d : 0);
      chk($sformatf("R3 hiz cycles d=%0d", d), n_hiz, PER - ad);
      chk($sformatf("R5 lock d=%0d", d), e_lock, lk);
      chk($sformatf("R7 cur_hi d=%0d", d), e_cur, 1 - lk);
      chk($sformatf("R7 auto_flag d=%0d", d), e_auto, 1 - lk);
      if (d > 0) chk($sformatf("R1 src start d=%0d", d), f_src, 6);
    end

    // R5 exact count, R6 drop
    cur_sel = 1'b1; tmode = 3'b000;
    do_reset();
    for (int p = 0; p < 3; p++) run_period(0);
    chk("R5 lock after 3", e_lock, 0);
    chk("R4 cur_hi unlocked", e_cur, 1);
    run_period(0);
    chk("R5 lock after 4", e_lock, 1);
    chk("R7 cur_hi locked", e_cur, 0);
    chk("R7 auto locked", e_auto, 0);
    run_period(TOL + 1);
    chk("R6 lock dropped", e_lock, 0);
    chk("R6 cur_hi restored", e_cur, 1);
    chk("R6 auto restored", e_auto, 1);

    // R8 pump off with low current, R7/R4 low current while locked
    cur_sel = 1'b0; tmode = 3'b000;
    do_reset();
    run_period(3);
    run_period(3);
    chk("R8 off src", n_src, 0);
    chk("R8 off snk", n_snk, 0);
    chk("R8 off hiz", n_hiz, PER);
    for (int p = 0; p < 6; p++) run_period(0);
    chk("R5 lock low cur", e_lock, 1);
    chk("R7 auto low cur", e_auto, 1);
    chk("R4 cur_hi low", e_cur, 0);

    // R8 and R9 test codes
    for (int m = 0; m < 8; m++) begin
      cur_sel = 1'b1; tmode = 3'(m);
      do_reset();
      run_period(2);
      run_period(2);
      chk($sformatf("R8 src code=%0d", m), n_src,
          (m == 3) ? PER : ((m == 0 || m == 5) ? 2 : 0));
      chk($sformatf("R8 snk code=%0d", m), n_snk, (m == 2) ? PER : 0);
      chk($sformatf("R9 test count code=%0d", m), n_test, (m == 4 || m == 5) ? 1 : 0);
      if (m == 4) chk("R9 ref routed", f_test, 7);
      if (m == 5) chk("R9 loc routed", f_test, 5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule